// File: doc/BRIEF.md
# Transceiver Interface Control Register with Set/Clear Aliases

This block holds one 8-bit control word in the link-side register file of a USB transceiver. Software reaches the word through three aliased addresses. One replaces the whole word, one ORs ones into it, and one removes the bits that are 1 in the data. A read at any of the three returns the stored value one cycle later, with a valid strobe. Addresses outside the three are left to other blocks in the register file.

The stored bits drive the transceiver's interface controls. These are the protect-circuit disable, indicator pass-through, fault-indicator inversion, an active-low clock-keep request and two serial-mode selects. The block also derives three outputs from the word: the fault indicator, optionally inverted; the clock-power decision, which honours the clock bit only in a serial mode while the transceiver is not suspended; and the stop-line protection enables. When the transceiver leaves a serial mode it reports the exit with a one-cycle event, and the matching mode bit is cleared in hardware.

Top module: `phy_ifctl_reg`

## Requirements
- R1: After reset every bit of the word is 0, so a read returns 00h.
- R2: A write to address 07h loads the word. The bit positions are: bit 7 protect disable, bit 6 pass-through, bit 5 fault invert, bit 3 clock keep (active low), bit 1 3-pin serial, bit 0 6-pin serial. Each stored bit appears on its control output.
- R3: A write to address 08h sets each bit where the data is 1 and leaves the others unchanged.
- R4: A write to address 09h clears each bit where the data is 1 and leaves the others unchanged.
- R5: A read at 07h, 08h or 09h sets rd_valid for one cycle, one cycle after the request, with rd_data equal to the stored word.
- R6: Writes and reads at any other address leave the word unchanged and never set rd_valid.
- R7: Bits 4 and 2 ignore writes and always read 0.
- R8: exit_3pin clears bit 1 and exit_6pin clears bit 0. If a register write to the same bit happens in the same cycle, the hardware clear wins.
- R9: fault_out equals fault_in when bit 5 is 0 and equals its inverse when bit 5 is 1.
- R10: clk_power equals bit 3 while phy_active is 1 and bit 1 or bit 0 is set. In every other case clk_power is 1.
- R11: When bit 7 is 0, stp_pullup_en is 1 and data_pulldown_en follows stp_in. When bit 7 is 1, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Register address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| exit_3pin | input | 1 | 3-pin serial mode exit event |
| exit_6pin | input | 1 | 6-pin serial mode exit event |
| phy_active | input | 1 | 1 when the transceiver is not suspended |
| fault_in | input | 1 | Fault indicator input |
| fault_out | output | 1 | Fault indicator, optionally inverted |
| stp_in | input | 1 | Sensed level of the stop line |
| prot_dis | output | 1 | Protect circuit disable (bit 7) |
| ind_passthru | output | 1 | Indicator pass-through (bit 6) |
| ind_invert | output | 1 | Fault invert (bit 5) |
| clk_keep_n | output | 1 | Clock keep request, active low (bit 3) |
| ser3_en | output | 1 | 3-pin serial mode select (bit 1) |
| ser6_en | output | 1 | 6-pin serial mode select (bit 0) |
| clk_power | output | 1 | Internal clock power decision |
| stp_pullup_en | output | 1 | Weak pull-up on stop line enable |
| data_pulldown_en | output | 1 | Weak pull-downs on data lines enable |

## Verification
The three write aliases are driven with all-ones and with masks that overlap the stored value. After each write, a read through a different alias tells load, set and clear apart and confirms that the reserved bits stay at 0. A write and a read at an unused address show that the block neither changes the word nor answers. Mode-exit events are given alone and together with a same-cycle set of the same bit, to show that the hardware clear wins. The clock decision is tried in four cases: serial mode with phy_active at 1 and the clock bit at 0, the same with the clock bit at 1, phy_active at 0, and no serial mode. Together these separate the gating terms.

// File: rtl/ifctl_pkg.sv
package ifctl_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_LOAD = 2'd1,
      OP_SET  = 2'd2,
      OP_CLR  = 2'd3
   } ifctl_op_e;

   localparam int BIT_PROT_DIS = 7;
   localparam int BIT_PASSTHRU = 6;
   localparam int BIT_INVERT   = 5;
   localparam int BIT_CLK_KEEP = 3;
   localparam int BIT_SER3     = 1;
   localparam int BIT_SER6     = 0;
   localparam logic [7:0] RSVD_MASK = 8'h14;
endpackage

// File: rtl/ifctl_decode.sv
module ifctl_decode
   import ifctl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] A_LOAD = 7,
   parameter logic [ADDR_W-1:0] A_SET  = 8,
   parameter logic [ADDR_W-1:0] A_CLR  = 9
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   output ifctl_op_e         op,
   output logic              rd_hit
);
   logic hit_load, hit_set, hit_clr, hit_any;

   assign hit_load = (acc_addr == A_LOAD);
   assign hit_set  = (acc_addr == A_SET);
   assign hit_clr  = (acc_addr == A_CLR);
   assign hit_any  = hit_load | hit_set | hit_clr;

   always_comb begin
      op = OP_NONE;
      if (acc_valid && acc_write) begin
         if (hit_load)     op = OP_LOAD;
         else if (hit_set) op = OP_SET;
         else if (hit_clr) op = OP_CLR;
      end
   end

   assign rd_hit = acc_valid & ~acc_write & hit_any;
endmodule

// File: rtl/ifctl_store.sv
module ifctl_store
   import ifctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] RSVD = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ifctl_op_e         op,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] hw_clr,
   output logic [DATA_W-1:0] word_q
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (RSVD[i]) begin : g_rsvd
         assign word_q[i] = 1'b0;
      end else begin : g_live
         logic nxt;
         always_comb begin
            unique case (op)
               OP_LOAD: nxt = wdata[i];
               OP_SET:  nxt = word_q[i] | wdata[i];
               OP_CLR:  nxt = word_q[i] & ~wdata[i];
               default: nxt = word_q[i];
            endcase
            if (hw_clr[i]) nxt = 1'b0;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q[i] <= 1'b0;
            else        word_q[i] <= nxt;
         end
      end
   end
endmodule

// File: rtl/ifctl_outputs.sv
module ifctl_outputs #(
   parameter bit FAULT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prot_dis,
   input  logic invert,
   input  logic clk_keep_n,
   input  logic ser3,
   input  logic ser6,
   input  logic phy_active,
   input  logic fault_in,
   input  logic stp_in,
   output logic fault_out,
   output logic clk_power,
   output logic stp_pullup_en,
   output logic data_pulldown_en
);
   logic serial_on, gate_on, fault_nxt;

   assign serial_on = ser3 | ser6;
   assign gate_on   = serial_on & phy_active;
   assign clk_power = gate_on ? clk_keep_n : 1'b1;

   assign stp_pullup_en    = ~prot_dis;
   assign data_pulldown_en = ~prot_dis & stp_in;

   assign fault_nxt = fault_in ^ invert;

   if (FAULT_REG) begin : g_fault_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fault_out <= 1'b0;
         else        fault_out <= fault_nxt;
      end
   end else begin : g_fault_comb
      assign fault_out = fault_nxt;
   end
endmodule

// File: rtl/phy_ifctl_reg.sv
module phy_ifctl_reg
   import ifctl_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] A_LOAD = 7,
   parameter logic [ADDR_W-1:0] A_SET  = 8,
   parameter logic [ADDR_W-1:0] A_CLR  = 9,
   parameter bit FAULT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              exit_3pin,
   input  logic              exit_6pin,
   input  logic              phy_active,
   input  logic              fault_in,
   output logic              fault_out,
   input  logic              stp_in,
   output logic              prot_dis,
   output logic              ind_passthru,
   output logic              ind_invert,
   output logic              clk_keep_n,
   output logic              ser3_en,
   output logic              ser6_en,
   output logic              clk_power,
   output logic              stp_pullup_en,
   output logic              data_pulldown_en
);
   localparam int MAX_ADDR = (1 << ADDR_W) - 1;

   if (DATA_W != 8) begin : g_bad_width
      $error("phy_ifctl_reg: DATA_W must be 8");
   end
   if (A_LOAD == A_SET || A_LOAD == A_CLR || A_SET == A_CLR) begin : g_bad_alias
      $error("phy_ifctl_reg: alias addresses must differ");
   end
   if (int'(A_CLR) > MAX_ADDR) begin : g_bad_addr
      $error("phy_ifctl_reg: address out of range");
   end

   ifctl_op_e         op;
   logic              rd_hit;
   logic [DATA_W-1:0] hw_clr;
   logic [DATA_W-1:0] word_q;

   ifctl_decode #(
      .ADDR_W(ADDR_W), .A_LOAD(A_LOAD), .A_SET(A_SET), .A_CLR(A_CLR)
   ) u_dec (
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .op(op), .rd_hit(rd_hit)
   );

   always_comb begin
      hw_clr = '0;
      hw_clr[BIT_SER3] = exit_3pin;
      hw_clr[BIT_SER6] = exit_6pin;
   end

   ifctl_store #(
      .DATA_W(DATA_W), .RSVD(RSVD_MASK)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .op(op), .wdata(acc_wdata),
      .hw_clr(hw_clr), .word_q(word_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_hit;
         if (rd_hit) rd_data <= word_q;
      end
   end

   assign prot_dis     = word_q[BIT_PROT_DIS];
   assign ind_passthru = word_q[BIT_PASSTHRU];
   assign ind_invert   = word_q[BIT_INVERT];
   assign clk_keep_n   = word_q[BIT_CLK_KEEP];
   assign ser3_en      = word_q[BIT_SER3];
   assign ser6_en      = word_q[BIT_SER6];

   ifctl_outputs #(.FAULT_REG(FAULT_REG)) u_out (
      .clk(clk), .rst_n(rst_n),
      .prot_dis(prot_dis), .invert(ind_invert), .clk_keep_n(clk_keep_n),
      .ser3(ser3_en), .ser6(ser6_en), .phy_active(phy_active),
      .fault_in(fault_in), .stp_in(stp_in),
      .fault_out(fault_out), .clk_power(clk_power),
      .stp_pullup_en(stp_pullup_en), .data_pulldown_en(data_pulldown_en)
   );
endmodule

// File: rtl/phy_ifctl_reg_chk.sv
module phy_ifctl_reg_chk #(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] A_LOAD = 7,
   parameter logic [ADDR_W-1:0] A_SET  = 8,
   parameter logic [ADDR_W-1:0] A_CLR  = 9,
   parameter bit FAULT_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic [7:0]        rd_data,
   input logic              rd_valid,
   input logic              exit_3pin,
   input logic              exit_6pin,
   input logic              phy_active,
   input logic              fault_in,
   input logic              fault_out,
   input logic              stp_in,
   input logic              prot_dis,
   input logic              ind_passthru,
   input logic              ind_invert,
   input logic              clk_keep_n,
   input logic              ser3_en,
   input logic              ser6_en,
   input logic              clk_power
);
   logic [7:0] w;
   logic       no_exit, wr, known;
   assign w = {prot_dis, ind_passthru, ind_invert, 1'b0, clk_keep_n, 1'b0, ser3_en, ser6_en};
   assign no_exit = ~exit_3pin & ~exit_6pin;
   assign wr = acc_valid & acc_write;
   assign known = (acc_addr == A_LOAD) || (acc_addr == A_SET) || (acc_addr == A_CLR);

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr && acc_addr == A_LOAD && no_exit |=> w == ($past(acc_wdata) & 8'hEB));
   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr && acc_addr == A_SET && no_exit |=> w == (($past(w) | $past(acc_wdata)) & 8'hEB));
   assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr && acc_addr == A_CLR && no_exit |=> w == ($past(w) & ~$past(acc_wdata)));
   assert_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_write && known |=> rd_valid && rd_data == $past(w));
   assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !known && no_exit |=> !rd_valid && $stable(w));
   assert_hwclr3_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_3pin |=> !ser3_en);
   assert_hwclr6_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_6pin |=> !ser6_en);
   assert_clkpow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(phy_active && (ser3_en || ser6_en)) |-> clk_power);

   if (!FAULT_REG) begin : g_fault_chk
      always_comb begin
         if (rst_n) assert_fault_R9: assert (fault_out == (fault_in ^ ind_invert));
      end
   end
endmodule

bind phy_ifctl_reg phy_ifctl_reg_chk #(
   .ADDR_W(ADDR_W), .A_LOAD(A_LOAD), .A_SET(A_SET), .A_CLR(A_CLR), .FAULT_REG(FAULT_REG)
) u_chk (.*);

// File: tb/tb_phy_ifctl_reg.sv
`timescale 1ns/1ps
module tb_phy_ifctl_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0, acc_write = 1'b0;
   logic [5:0] acc_addr = '0;
   logic [7:0] acc_wdata = '0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       exit_3pin = 1'b0, exit_6pin = 1'b0;
   logic       phy_active = 1'b0, fault_in = 1'b0, stp_in = 1'b0;
   logic       fault_out, prot_dis, ind_passthru, ind_invert, clk_keep_n;
   logic       ser3_en, ser6_en, clk_power, stp_pullup_en, data_pulldown_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [7:0] model = '0;
   logic [7:0] exp_q[$];
   string      req_q[$];

   always #2 clk = ~clk;

   phy_ifctl_reg dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R6", 1, 0);
         else begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(rd_data == e, r, rd_data, e);
         end
      end
   end

   function automatic bit known(input logic [5:0] a);
      return a == 6'd7 || a == 6'd8 || a == 6'd9;
   endfunction

   task automatic wr(input logic [5:0] a, input logic [7:0] d, input bit e3 = 0, input bit e6 = 0);
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
      exit_3pin = e3; exit_6pin = e6;
      if (a == 6'd7)      model = d;
      else if (a == 6'd8) model = model | d;
      else if (a == 6'd9) model = model & ~d;
      model = model & 8'hEB;
      if (e3) model[1] = 1'b0;
      if (e6) model[0] = 1'b0;
      @(negedge clk);
      acc_valid = 0; acc_write = 0; exit_3pin = 0; exit_6pin = 0;
   endtask

   task automatic rd(input logic [5:0] a, input string req);
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_addr = a;
      if (known(a)) begin exp_q.push_back(model); req_q.push_back(req); end
      @(negedge clk);
      acc_valid = 0;
      @(negedge clk);
   endtask

   task automatic pulse_exit(input bit e3, input bit e6);
      @(negedge clk);
      exit_3pin = e3; exit_6pin = e6;
      if (e3) model[1] = 1'b0;
      if (e6) model[0] = 1'b0;
      @(negedge clk);
      exit_3pin = 0; exit_6pin = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state at the ports
      check({prot_dis, ind_passthru, ind_invert, clk_keep_n, ser3_en, ser6_en} == 0, "R1", 1, 0);
      rd(6'd7, "R1");
      // R2 load all ones, R7 reserved bits stay 0
      wr(6'd7, 8'hFF);
      #1 check({prot_dis, ind_passthru, ind_invert, clk_keep_n, ser3_en, ser6_en} == 6'h3F, "R2", 0, 6'h3F);
      rd(6'd8, "R7");
      // R4 clear low nibble, read through another alias
      wr(6'd9, 8'h0F);
      rd(6'd9, "R4");
      // R3 set bit 1 only
      wr(6'd8, 8'h02);
      rd(6'd7, "R3");
      // R6 unused address: write and read
      wr(6'd10, 8'hFF);
      rd(6'd10, "R6");
      rd(6'd7, "R6");
      rd(6'd9, "R5");
      // R8 exit event alone, then exit colliding with a set
      pulse_exit(1'b1, 1'b0);
      rd(6'd8, "R8");
      wr(6'd8, 8'h01, 1'b0, 1'b1);
      rd(6'd7, "R8");
      // R9 fault path both polarities
      wr(6'd7, 8'h00);
      fault_in = 1'b1; #1 check(fault_out == 1'b1, "R9", fault_out, 1);
      wr(6'd8, 8'h20);
      #1 check(fault_out == 1'b0, "R9", fault_out, 0);
      fault_in = 1'b0; #1 check(fault_out == 1'b1, "R9", fault_out, 1);
      // R10 clock power gating
      wr(6'd7, 8'h02); phy_active = 1'b1;
      #1 check(clk_power == 1'b0, "R10", clk_power, 0);
      phy_active = 1'b0;
      #1 check(clk_power == 1'b1, "R10", clk_power, 1);
      phy_active = 1'b1;
      wr(6'd8, 8'h08);
      #1 check(clk_power == 1'b1, "R10", clk_power, 1);
      wr(6'd7, 8'h00);
      #1 check(clk_power == 1'b1, "R10", clk_power, 1);
      wr(6'd7, 8'h01);
      #1 check(clk_power == 1'b0, "R10", clk_power, 0);
      // R11 protect outputs
      wr(6'd7, 8'h00); stp_in = 1'b1;
      #1 check(stp_pullup_en && data_pulldown_en, "R11", {stp_pullup_en, data_pulldown_en}, 3);
      stp_in = 1'b0;
      #1 check(stp_pullup_en && !data_pulldown_en, "R11", {stp_pullup_en, data_pulldown_en}, 2);
      wr(6'd8, 8'h80); stp_in = 1'b1;
      #1 check(!stp_pullup_en && !data_pulldown_en, "R11", {stp_pullup_en, data_pulldown_en}, 0);
      rd(6'd9, "R5");
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R5", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule